// File: doc/BRIEF.md
# Shared-Line Monitor Data Serializer

This block turns one amplifier's monitor samples into a serial stream on a data wire. Two identical copies of the block can share that wire. Each copy latches a strap pin during reset to learn whether it is identity 0 or identity 1. With pairing enabled, identity 0 owns the left half of each frame and identity 1 owns the right half. Outside its own half, the block releases the wire to high impedance. With pairing disabled, a single block drives both halves.

A bit clock and a frame clock pace the stream. Both arrive as level inputs that are synchronous to the system clock, and the block finds their edges itself.

At the start of each owned slot, the block captures a 32-bit payload and shifts it out MSB first, one bit per falling bit-clock edge. A 2-bit selector picks the payload layout, built from a voltage word, a current word, a supply word and eight status flags. An output-hold control forces the wire to high impedance whatever the slot.

Top module: `mon_slot_serializer`

## Requirements
- R1: `strap_id` is copied into the identity while `rst` is high. The value present in the last reset cycle is held until the next reset, so later strap changes have no effect.
- R2: With `pair_mode`=1, identity 0 asserts `sdout_oe` only in slots opened with `fclk`=0 (left), and identity 1 only in slots opened with `fclk`=1 (right).
- R3: While `out_hiz`=1, `sdout_oe` is 0 in every slot.
- R4: With `pair_mode`=0 and `out_hiz`=0, `sdout_oe` is 1 in both slots, whatever the identity.
- R5: A slot opens on the falling `bclk` edge at which `fclk` differs from its level at the previous falling edge. The payload MSB appears on `sdout` after that edge, and each later falling edge advances one bit. After reset, nothing is driven until the first slot opens.
- R6: `pack_sel`=00 sends vmon[15:4], then imon[15:4], then vpmon[7:0].
- R7: `pack_sel`=01 sends vmon[15:4], then imon[15:4], then status[7:0]. The flags go in the order status[7] amp short, [6] overtemperature warning, [5] overtemperature error, [4] V/I monitor overflow, [3] supply monitor overflow, [2] power-down done, [1] boost current limit, [0] LED timer on.
- R8: `pack_sel`=10 sends vmon[15:0], then imon[15:0].
- R9: `pack_sel`=11 sends vpmon[7:0], then status[7:0], then 16 zero bits.
- R10: Bit positions past the 32nd in a slot are sent as 0.
- R11: The payload is captured when the slot opens. Changes on the monitor inputs or `pack_sel` after that do not alter the slot being sent.
- R12: After reset, `sdout_oe` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset; strap sampled while high |
| strap_id | input | 1 | Identity strap level |
| bclk | input | 1 | Bit clock level, synchronous to clk |
| fclk | input | 1 | Frame clock level: 0 left slot, 1 right slot |
| out_hiz | input | 1 | 1 keeps the output released |
| pair_mode | input | 1 | 1 enables identity-based slot ownership |
| pack_sel | input | 2 | Payload layout selector |
| vmon | input | 16 | Voltage monitor word |
| imon | input | 16 | Current monitor word |
| vpmon | input | 8 | Supply monitor word |
| status | input | 8 | Status flags, bit 7 sent first |
| sdout | output | 1 | Serial data, high impedance when not driven |
| sdout_oe | output | 1 | High while the block drives sdout |

## Verification
The bench sweeps both identities, both pairing settings, all four layouts and several data patterns over full frames. It compares each sent bit with a word it builds itself from the layout rules.

The slots are stretched to 34 bits to catch a design that shifts in stale bits instead of zeros. The monitor inputs are flipped right after a slot opens to catch one that reads them live rather than capturing them. The strap is changed after reset to catch one that tracks the pin instead of latching it. The output-hold control is set across whole frames to catch one that still drives in its own slot.

// File: rtl/mon_ser_pkg.sv
package mon_ser_pkg;

    localparam int SLOT_W = 32;
    localparam int HI_W   = 16;
    localparam int LO_W   = 12;
    localparam int SUP_W  = 8;
    localparam int STAT_W = 8;
    localparam int PAD_W  = SLOT_W - SUP_W - STAT_W;

    typedef enum logic [1:0] {
        PK_VI12_SUP  = 2'b00,
        PK_VI12_STAT = 2'b01,
        PK_VI16      = 2'b10,
        PK_SUP_STAT  = 2'b11
    } pack_mode_e;

    typedef struct packed {
        logic [HI_W-1:0]   volt;
        logic [HI_W-1:0]   curr;
        logic [SUP_W-1:0]  supply;
        logic [STAT_W-1:0] flags;
    } mon_sample_t;

    typedef logic [SLOT_W-1:0] slot_word_t;

    function automatic slot_word_t build_slot(pack_mode_e m, mon_sample_t s);
        slot_word_t w;
        case (m)
            PK_VI12_SUP:  w = {s.volt[HI_W-1 -: LO_W], s.curr[HI_W-1 -: LO_W], s.supply};
            PK_VI12_STAT: w = {s.volt[HI_W-1 -: LO_W], s.curr[HI_W-1 -: LO_W], s.flags};
            PK_VI16:      w = {s.volt, s.curr};
            default:      w = {s.supply, s.flags, {PAD_W{1'b0}}};
        endcase
        return w;
    endfunction

endpackage

// File: rtl/mon_strap_latch.sv
module mon_strap_latch (
    input  logic clk,
    input  logic rst,
    input  logic strap,
    output logic id_q
);
    always_ff @(posedge clk) begin
        if (rst) id_q <= strap;
    end
endmodule

// File: rtl/mon_frame_track.sv
module mon_frame_track (
    input  logic clk,
    input  logic rst,
    input  logic bclk,
    input  logic fclk,
    output logic bit_fall,
    output logic slot_go,
    output logic slot_side,
    output logic framed
);
    logic bclk_q;
    logic fclk_last;
    logic seen;

    assign bit_fall = bclk_q & ~bclk;
    assign slot_go  = bit_fall & seen & (fclk != fclk_last);

    always_ff @(posedge clk) begin
        if (rst) begin
            bclk_q    <= 1'b0;
            fclk_last <= 1'b0;
            seen      <= 1'b0;
            framed    <= 1'b0;
            slot_side <= 1'b0;
        end else begin
            bclk_q <= bclk;
            if (bit_fall) begin
                seen      <= 1'b1;
                fclk_last <= fclk;
            end
            if (slot_go) begin
                framed    <= 1'b1;
                slot_side <= fclk;
            end
        end
    end
endmodule

// File: rtl/mon_payload_pack.sv
module mon_payload_pack
    import mon_ser_pkg::*;
(
    input  logic [1:0]        sel,
    input  logic [HI_W-1:0]   volt,
    input  logic [HI_W-1:0]   curr,
    input  logic [SUP_W-1:0]  supply,
    input  logic [STAT_W-1:0] flags,
    output slot_word_t        word
);
    mon_sample_t smp;

    always_comb begin
        smp.volt   = volt;
        smp.curr   = curr;
        smp.supply = supply;
        smp.flags  = flags;
        word       = build_slot(pack_mode_e'(sel), smp);
    end
endmodule

// File: rtl/mon_slot_shifter.sv
module mon_slot_shifter #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         bit_fall,
    input  logic         slot_go,
    input  logic [W-1:0] load_word,
    output logic         ser_bit
);
    logic [W-1:0] sh;

    always_ff @(posedge clk) begin
        if (rst)           sh <= '0;
        else if (slot_go)  sh <= load_word;
        else if (bit_fall) sh <= {sh[W-2:0], 1'b0};
    end

    assign ser_bit = sh[W-1];
endmodule

// File: rtl/mon_slot_serializer.sv
module mon_slot_serializer
    import mon_ser_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              strap_id,
    input  logic              bclk,
    input  logic              fclk,
    input  logic              out_hiz,
    input  logic              pair_mode,
    input  logic [1:0]        pack_sel,
    input  logic [HI_W-1:0]   vmon,
    input  logic [HI_W-1:0]   imon,
    input  logic [SUP_W-1:0]  vpmon,
    input  logic [STAT_W-1:0] status,
    output wire               sdout,
    output logic              sdout_oe
);
    logic       id_q;
    logic       bit_fall;
    logic       slot_go;
    logic       slot_side;
    logic       framed;
    logic       ser_bit;
    logic       owned;
    slot_word_t word;

    mon_strap_latch u_strap (
        .clk   (clk),
        .rst   (rst),
        .strap (strap_id),
        .id_q  (id_q)
    );

    mon_frame_track u_track (
        .clk       (clk),
        .rst       (rst),
        .bclk      (bclk),
        .fclk      (fclk),
        .bit_fall  (bit_fall),
        .slot_go   (slot_go),
        .slot_side (slot_side),
        .framed    (framed)
    );

    mon_payload_pack u_pack (
        .sel    (pack_sel),
        .volt   (vmon),
        .curr   (imon),
        .supply (vpmon),
        .flags  (status),
        .word   (word)
    );

    mon_slot_shifter #(.W(SLOT_W)) u_shift (
        .clk       (clk),
        .rst       (rst),
        .bit_fall  (bit_fall),
        .slot_go   (slot_go),
        .load_word (word),
        .ser_bit   (ser_bit)
    );

    assign owned    = ~pair_mode | (slot_side == id_q);
    assign sdout_oe = framed & owned & ~out_hiz;
    assign sdout    = sdout_oe ? ser_bit : 1'bz;
endmodule

// File: rtl/mon_slot_serializer_chk.sv
module mon_slot_serializer_chk (
    input logic clk,
    input logic rst,
    input logic out_hiz,
    input logic pair_mode,
    input logic sdout_oe,
    input logic id_q,
    input logic slot_side,
    input logic framed,
    input logic bit_fall,
    input logic ser_bit
);
    assert_strap_hold_R1: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> $stable(id_q));

    assert_owner_slot_R2: assert property (@(posedge clk) disable iff (rst)
        (pair_mode && sdout_oe) |-> (slot_side == id_q));

    assert_hiz_release_R3: assert property (@(posedge clk) disable iff (rst)
        out_hiz |-> !sdout_oe);

    assert_single_drive_R4: assert property (@(posedge clk) disable iff (rst)
        (!pair_mode && framed && !out_hiz) |-> sdout_oe);

    assert_no_early_drive_R5: assert property (@(posedge clk) disable iff (rst)
        !framed |-> !sdout_oe);

    assert_bit_hold_R5: assert property (@(posedge clk) disable iff (rst)
        !bit_fall |=> $stable(ser_bit));
endmodule

bind mon_slot_serializer mon_slot_serializer_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .out_hiz   (out_hiz),
    .pair_mode (pair_mode),
    .sdout_oe  (sdout_oe),
    .id_q      (id_q),
    .slot_side (slot_side),
    .framed    (framed),
    .bit_fall  (bit_fall),
    .ser_bit   (ser_bit)
);

// File: tb/mon_slot_serializer_bench.sv
module mon_slot_serializer_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        strap_id = 1'b0;
    logic        bclk = 1'b0;
    logic        fclk = 1'b0;
    logic        out_hiz = 1'b0;
    logic        pair_mode = 1'b1;
    logic [1:0]  pack_sel = 2'b00;
    logic [15:0] vmon = '0;
    logic [15:0] imon = '0;
    logic [7:0]  vpmon = '0;
    logic [7:0]  status = '0;
    wire         sdout;
    logic        sdout_oe;

    int checks = 0;
    int errors = 0;
    bit done = 0;
    logic s_d, s_oe;

    mon_slot_serializer u_mon_slot_serializer (
        .clk(clk), .rst(rst), .strap_id(strap_id), .bclk(bclk), .fclk(fclk),
        .out_hiz(out_hiz), .pair_mode(pair_mode), .pack_sel(pack_sel),
        .vmon(vmon), .imon(imon), .vpmon(vpmon), .status(status),
        .sdout(sdout), .sdout_oe(sdout_oe)
    );

    always #10 clk = ~clk;

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] expect_word(input logic [1:0] m, input logic [15:0] v,
            input logic [15:0] i, input logic [7:0] s, input logic [7:0] f);
        logic [31:0] w;
        case (m)
            2'b00:   w = ({20'd0, v[15:4]} << 20) | ({20'd0, i[15:4]} << 8) | {24'd0, s};
            2'b01:   w = ({20'd0, v[15:4]} << 20) | ({20'd0, i[15:4]} << 8) | {24'd0, f};
            2'b10:   w = {16'd0, v} * 32'h10000 + {16'd0, i};
            default: w = ({24'd0, s} << 24) | ({24'd0, f} << 16);
        endcase
        return w;
    endfunction

    function automatic string mode_tag(input logic [1:0] m);
        case (m)
            2'b00:   return "R6";
            2'b01:   return "R7";
            2'b10:   return "R8";
            default: return "R9";
        endcase
    endfunction

    task automatic tick(input logic lr);
        bclk = 1'b0;
        fclk = lr;
        @(negedge clk);
        s_d  = sdout;
        s_oe = sdout_oe;
        bclk = 1'b1;
        @(negedge clk);
    endtask

    task automatic do_reset(input logic strap);
        rst = 1'b1;
        strap_id = strap;
        bclk = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(sdout_oe == 1'b0, "R12", {31'd0, sdout_oe}, 32'd0);
        bclk = 1'b1;
        @(negedge clk);
        tick(1'b1);
        check(s_oe == 1'b0, "R5", {31'd0, s_oe}, 32'd0);
    endtask

    task automatic run_slot(input logic lr, input logic exp_own, input string own_tag,
            input string data_tag, input bit tweak);
        logic [31:0] w;
        logic        eb;
        w = expect_word(pack_sel, vmon, imon, vpmon, status);
        for (int b = 0; b < 34; b++) begin
            tick(lr);
            check(s_oe == exp_own, own_tag, {31'd0, s_oe}, {31'd0, exp_own});
            if (exp_own) begin
                eb = (b < 32) ? w[31-b] : 1'b0;
                check(s_d == eb, (b < 32) ? data_tag : "R10", {31'd0, s_d}, {31'd0, eb});
            end
            if (tweak && b == 0) begin
                vmon = ~vmon; imon = ~imon; vpmon = ~vpmon; status = ~status;
                pack_sel = pack_sel ^ 2'b11;
            end
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (2) @(negedge clk);
        // Full sweep: identity, pairing, layout, data pattern
        for (int id = 0; id < 2; id++) begin
            do_reset(id[0]);
            for (int sh = 0; sh < 2; sh++) begin
                for (int m = 0; m < 4; m++) begin
                    for (int p = 0; p < 3; p++) begin
                        pair_mode = sh[0];
                        out_hiz   = 1'b0;
                        pack_sel  = m[1:0];
                        vmon   = 16'hA5C3 ^ 16'(p * 16'h1357);
                        imon   = 16'h3C96 + 16'(p * 16'h0F0F);
                        vpmon  = 8'h81 ^ 8'(p * 8'h3B);
                        status = 8'hD2 + 8'(p * 8'h47);
                        run_slot(1'b0, (!sh[0]) || (id == 0), sh[0] ? "R2" : "R4", mode_tag(m[1:0]), 1'b0);
                        run_slot(1'b1, (!sh[0]) || (id == 1), sh[0] ? "R2" : "R4", mode_tag(m[1:0]), 1'b0);
                    end
                end
            end
        end

        // Output hold: released in both slots, paired and unpaired
        out_hiz = 1'b1;
        pair_mode = 1'b1;
        run_slot(1'b0, 1'b0, "R3", "R3", 1'b0);
        run_slot(1'b1, 1'b0, "R3", "R3", 1'b0);
        pair_mode = 1'b0;
        run_slot(1'b0, 1'b0, "R3", "R3", 1'b0);
        run_slot(1'b1, 1'b0, "R3", "R3", 1'b0);
        out_hiz = 1'b0;

        // Capture at slot start: inputs flipped after the MSB
        pair_mode = 1'b0;
        pack_sel = 2'b10;
        vmon = 16'h1234; imon = 16'hFEDC;
        run_slot(1'b0, 1'b1, "R4", "R11", 1'b1);
        pack_sel = 2'b01;
        vmon = 16'h8F01; imon = 16'h70A5; status = 8'h96;
        run_slot(1'b1, 1'b1, "R4", "R11", 1'b1);

        // Strap latched in reset, later pin changes ignored
        do_reset(1'b1);
        strap_id = 1'b0;
        pair_mode = 1'b1;
        pack_sel = 2'b11;
        vpmon = 8'h5A; status = 8'hC3;
        run_slot(1'b0, 1'b0, "R1", "R9", 1'b0);
        run_slot(1'b1, 1'b1, "R1", "R9", 1'b0);
        strap_id = 1'b1;
        do_reset(1'b0);
        strap_id = 1'b1;
        run_slot(1'b0, 1'b1, "R1", "R9", 1'b0);
        run_slot(1'b1, 1'b0, "R1", "R9", 1'b0);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule